// File: doc/BRIEF.md
# Completion Queue Posting Engine

This block places completion entries into a circular completion ring held in host memory. Upstream logic presents finished commands one at a time. Each one carries a command identifier, the id of the submission queue it came from, that submission queue's current head and a 15-bit status code. The engine turns each command into a 128-bit entry and issues a memory write to the next free slot. It keeps the ring's tail pointer and phase tag. It holds the head pointer that host software reports through a side input.

Software sets up the ring with a one-cycle `cfg_load` pulse. The pulse latches the base address, the zero-based ring size and the interrupt settings. It also clears tail and head and sets the phase tag to 1.

The completion input and the memory-write output both use valid/ready. `wr_valid` is raised only when a completion is pending, the ring is loaded, no load is in progress and the ring is not full. `cpl_ready` is high exactly when `wr_valid` and `wr_ready` are both high, so a completion leaves the input in the same cycle its write is accepted. The block holds no buffer of its own. Back-pressure from either a stalled write port or a full ring therefore reaches the completion source directly, and completions are posted strictly in arrival order.

A batch of postings ends with the first cycle in which no write is accepted. On the cycle after that, the engine raises one interrupt pulse: on the vectored output if vectored interrupts are selected, on the pin output otherwise, and on neither if interrupts are disabled for the ring.

Top module: `cq_post_engine`

## Requirements
- R1: Before any `cfg_load`, `wr_valid` and `cpl_ready` stay low. After `cfg_load`, the first entry goes to the base address with phase bit 1.
- R2: The entry is packed, from MSB down, as: [127:113] status code, [112] phase tag, [111:96] command id, [95:80] submission queue id, [79:64] submission queue head, [63:0] zero.
- R3: `wr_addr` equals base + tail × 2^ESZ_LOG2, which is 16 bytes per slot at the default.
- R4: The tail advances only in a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the address and entry are held.
- R5: When the tail advances from the last slot, it wraps to 0 and the phase tag inverts for every later entry.
- R6: When (tail + 1) mod depth equals head, `wr_valid` and `cpl_ready` are low and the pending completion stays at the input.
- R7: A head write with a value ≥ depth is ignored. A head write with a value < depth replaces the head at the next edge.
- R8: `cpl_ready` is high exactly when `wr_valid` and `wr_ready` are both high. Completions are posted in arrival order.
- R9: With interrupts enabled and vectored mode selected, `irq_msg_valid` pulses for one cycle with `irq_msg_vector` equal to the loaded vector. The pulse comes one cycle after the first non-accepting cycle that follows an accepted write.
- R10: With interrupts enabled and vectored mode off, `irq_pin_pulse` pulses at that point instead. With interrupts disabled, neither output fires. The two outputs are never high together.
- R11: The ring depth is the loaded `cfg_qsize` + 1. For example, a loaded size of 1 holds a single outstanding entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle pulse that sets up the ring and clears its pointers |
| cfg_base | input | ADDR_W | Ring base address, latched on load |
| cfg_qsize | input | PTR_W | Zero-based ring size, latched on load |
| cfg_irq_en | input | 1 | Interrupts enabled for this ring |
| cfg_vec_en | input | 1 | 1 selects a vectored message, 0 selects the pin pulse |
| cfg_vector | input | VEC_W | Interrupt vector number |
| cpl_valid | input | 1 | A completion is pending |
| cpl_ready | output | 1 | The completion is consumed this cycle |
| cpl_cid | input | 16 | Command identifier |
| cpl_sqid | input | 16 | Submission queue id |
| cpl_sq_head | input | 16 | Submission queue head pointer |
| cpl_status | input | 15 | Status code |
| head_we | input | 1 | Host head update strobe |
| head_val | input | PTR_W | New head value |
| wr_valid | output | 1 | A memory write is requested |
| wr_ready | input | 1 | The memory write is accepted |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 128 | Packed completion entry |
| irq_msg_valid | output | 1 | Vectored interrupt pulse |
| irq_msg_vector | output | VEC_W | Vector for the vectored interrupt |
| irq_pin_pulse | output | 1 | Pin interrupt pulse |

## Verification
The posting path is tested under three kinds of write acceptance: a write port that is always ready, one held off for several cycles, and one that accepts at random. These show whether the tail moves only on a real handshake and whether a stalled entry stays intact. Completion arrival is also gapped at random, which moves where batches end and so shows whether the interrupt is timed from the first idle cycle. The ring is driven to full, then the host writes an out-of-range head (which must leave it stalled) and then a valid head (which must release it). This separates the full test and the head range check from ordinary back-pressure. Depths of 2, 4 and 8 are run through several wraps, which separates correct phase inversion and address wrap from off-by-one ring sizing, with each interrupt mode in turn.

// File: rtl/cqpe_pkg.sv
package cqpe_pkg;
  localparam int ENTRY_W = 128;
  localparam int CODE_W  = 15;

  function automatic logic [ENTRY_W-1:0] pack_entry(
    input logic [CODE_W-1:0] code,
    input logic              phase,
    input logic [15:0]       cid,
    input logic [15:0]       sqid,
    input logic [15:0]       sq_head
  );
    return {code, phase, cid, sqid, sq_head, 64'd0};
  endfunction
endpackage

// File: rtl/cqpe_ring.sv
module cqpe_ring #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] qsize,
  input  logic             adv,
  input  logic             head_we,
  input  logic [PTR_W-1:0] head_val,
  output logic [PTR_W-1:0] tail,
  output logic             phase,
  output logic             full
);
  logic [PTR_W-1:0] tail_q, head_q, last_q, tail_inc;
  logic             phase_q, at_last;

  always_comb begin
    at_last  = (tail_q == last_q);
    tail_inc = at_last ? '0 : tail_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail_q  <= '0;
      head_q  <= '0;
      last_q  <= '0;
      phase_q <= 1'b1;
    end else if (load) begin
      tail_q  <= '0;
      head_q  <= '0;
      last_q  <= qsize;
      phase_q <= 1'b1;
    end else begin
      if (adv) begin
        tail_q <= tail_inc;
        if (at_last) phase_q <= ~phase_q;
      end
      if (head_we && (head_val <= last_q)) head_q <= head_val;
    end
  end

  assign tail  = tail_q;
  assign phase = phase_q;
  assign full  = (tail_inc == head_q);

  // R5
  wrap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && at_last) |=> (tail_q == '0 && phase_q != $past(phase_q)));

  // R4
  tail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(tail_q));

  // R7
  head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_we && !load && head_val > last_q) |=> $stable(head_q));
endmodule

// File: rtl/cqpe_entry_fmt.sv
module cqpe_entry_fmt
  import cqpe_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PTR_W    = 16,
  parameter int ESZ_LOG2 = 4
) (
  input  logic [ADDR_W-1:0]  base,
  input  logic [PTR_W-1:0]   tail,
  input  logic               phase,
  input  logic [15:0]        cid,
  input  logic [15:0]        sqid,
  input  logic [15:0]        sq_head,
  input  logic [CODE_W-1:0]  code,
  output logic [ADDR_W-1:0]  addr,
  output logic [ENTRY_W-1:0] data
);
  logic [ADDR_W-1:0] slot_off;

  always_comb begin
    slot_off = ADDR_W'(tail) << ESZ_LOG2;
    addr     = base + slot_off;
    data     = pack_entry(code, phase, cid, sqid, sq_head);
  end
endmodule

// File: rtl/cqpe_irq.sv
module cqpe_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic acc,
  input  logic irq_en,
  input  logic vec_en,
  output logic msg,
  output logic pin
);
  logic posted_q, msg_q, pin_q, batch_end;

  assign batch_end = posted_q && !acc;

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      posted_q <= 1'b0;
      msg_q    <= 1'b0;
      pin_q    <= 1'b0;
    end else begin
      posted_q <= acc;
      msg_q    <= batch_end && irq_en && vec_en;
      pin_q    <= batch_end && irq_en && !vec_en;
    end
  end

  assign msg = msg_q;
  assign pin = pin_q;

  // R10
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msg_q, pin_q}));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_q || pin_q) |-> ($past(posted_q) && !$past(acc)));
endmodule

// File: rtl/cq_post_engine.sv
module cq_post_engine
  import cqpe_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PTR_W    = 16,
  parameter int VEC_W    = 8,
  parameter int ESZ_LOG2 = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [PTR_W-1:0]   cfg_qsize,
  input  logic               cfg_irq_en,
  input  logic               cfg_vec_en,
  input  logic [VEC_W-1:0]   cfg_vector,
  input  logic               cpl_valid,
  output logic               cpl_ready,
  input  logic [15:0]        cpl_cid,
  input  logic [15:0]        cpl_sqid,
  input  logic [15:0]        cpl_sq_head,
  input  logic [CODE_W-1:0]  cpl_status,
  input  logic               head_we,
  input  logic [PTR_W-1:0]   head_val,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [ENTRY_W-1:0] wr_data,
  output logic               irq_msg_valid,
  output logic [VEC_W-1:0]   irq_msg_vector,
  output logic               irq_pin_pulse
);
  logic [ADDR_W-1:0] base_q;
  logic [VEC_W-1:0]  vec_q;
  logic              active_q, ien_q, ven_q;
  logic [PTR_W-1:0]  ring_tail;
  logic              ring_phase, ring_full, post_ok, accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      vec_q    <= '0;
      ien_q    <= 1'b0;
      ven_q    <= 1'b0;
    end else if (cfg_load) begin
      active_q <= 1'b1;
      base_q   <= cfg_base;
      vec_q    <= cfg_vector;
      ien_q    <= cfg_irq_en;
      ven_q    <= cfg_vec_en;
    end
  end

  assign post_ok   = active_q && !cfg_load && !ring_full;
  assign wr_valid  = post_ok && cpl_valid;
  assign accept    = wr_valid && wr_ready;
  assign cpl_ready = accept;

  cqpe_ring #(.PTR_W(PTR_W)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .qsize    (cfg_qsize),
    .adv      (accept),
    .head_we  (head_we),
    .head_val (head_val),
    .tail     (ring_tail),
    .phase    (ring_phase),
    .full     (ring_full)
  );

  cqpe_entry_fmt #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .ESZ_LOG2(ESZ_LOG2)) u_fmt (
    .base    (base_q),
    .tail    (ring_tail),
    .phase   (ring_phase),
    .cid     (cpl_cid),
    .sqid    (cpl_sqid),
    .sq_head (cpl_sq_head),
    .code    (cpl_status),
    .addr    (wr_addr),
    .data    (wr_data)
  );

  cqpe_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cfg_load),
    .acc    (accept),
    .irq_en (ien_q),
    .vec_en (ven_q),
    .msg    (irq_msg_valid),
    .pin    (irq_pin_pulse)
  );

  assign irq_msg_vector = vec_q;

  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ring_full |-> !wr_valid);

  // R8
  handshake_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_ready |=> (ring_tail != $past(ring_tail)));

  // R1
  idle_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (!wr_valid && !cpl_ready));
endmodule

// File: tb/cq_post_engine_tb.sv
module cq_post_engine_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_load, cfg_irq_en, cfg_vec_en;
  logic [31:0]  cfg_base;
  logic [15:0]  cfg_qsize, head_val;
  logic [7:0]   cfg_vector;
  logic         cpl_valid, cpl_ready, head_we, wr_valid, wr_ready;
  logic [15:0]  cpl_cid, cpl_sqid, cpl_sq_head;
  logic [14:0]  cpl_status;
  logic [31:0]  wr_addr;
  logic [127:0] wr_data;
  logic         irq_msg_valid, irq_pin_pulse;
  logic [7:0]   irq_msg_vector;

  always #5 clk = ~clk;

  cq_post_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_qsize(cfg_qsize), .cfg_irq_en(cfg_irq_en), .cfg_vec_en(cfg_vec_en),
    .cfg_vector(cfg_vector), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_cid(cpl_cid), .cpl_sqid(cpl_sqid), .cpl_sq_head(cpl_sq_head),
    .cpl_status(cpl_status), .head_we(head_we), .head_val(head_val),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_msg_valid(irq_msg_valid), .irq_msg_vector(irq_msg_vector),
    .irq_pin_pulse(irq_pin_pulse)
  );

  int n_vec = 0;
  int n_bad = 0;
  logic [62:0] pend[$];
  int cid_ctr = 1;
  bit feed_en = 1'b1;
  int rdy_mode = 0;

  // reference model state
  bit m_active = 0, m_phase = 1, m_posted = 0, m_msg = 0, m_pin = 0, m_ien = 0, m_ven = 0;
  int m_tail = 0, m_head = 0, m_last = 0;
  logic [31:0] m_base = 0;
  logic [7:0]  m_vec = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int nxt_tail();
    return (m_tail == m_last) ? 0 : m_tail + 1;
  endfunction

  function automatic bit exp_wv();
    return m_active && !cfg_load && cpl_valid && (nxt_tail() != m_head);
  endfunction

  task automatic push();
    pend.push_back({16'(cid_ctr), 16'($urandom_range(1, 8)), 16'($urandom), 15'($urandom)});
    cid_ctr++;
  endtask

  task automatic drive();
    cpl_valid = feed_en && (pend.size() > 0);
    if (pend.size() > 0) {cpl_cid, cpl_sqid, cpl_sq_head, cpl_status} = pend[0];
    case (rdy_mode)
      0: wr_ready = 1'b1;
      1: wr_ready = 1'($urandom_range(0, 1));
      default: wr_ready = 1'b0;
    endcase
  endtask

  task automatic compare();
    bit ewv;
    logic [127:0] ed;
    ewv = exp_wv();
    chk(wr_valid === ewv, "R6", 128'(wr_valid), 128'(ewv));
    chk(cpl_ready === (ewv && wr_ready), "R8", 128'(cpl_ready), 128'(ewv && wr_ready));
    if (ewv) begin
      chk(wr_addr === 32'(m_base + 32'(m_tail) * 32'd16), "R3", 128'(wr_addr),
          128'(32'(m_base + 32'(m_tail) * 32'd16)));
      ed = {cpl_status, m_phase, cpl_cid, cpl_sqid, cpl_sq_head, 64'd0};
      chk(wr_data === ed, "R2", wr_data, ed);
    end
    chk(irq_msg_valid === m_msg, "R9", 128'(irq_msg_valid), 128'(m_msg));
    if (m_msg) chk(irq_msg_vector === m_vec, "R9", 128'(irq_msg_vector), 128'(m_vec));
    chk(irq_pin_pulse === m_pin, "R10", 128'(irq_pin_pulse), 128'(m_pin));
  endtask

  task automatic advance();
    bit acc, fire;
    int nt;
    acc = exp_wv() && wr_ready;
    nt  = nxt_tail();
    @(posedge clk); #1;
    if (!rst_n) begin
      m_active = 0; m_tail = 0; m_head = 0; m_last = 0; m_phase = 1;
      m_posted = 0; m_msg = 0; m_pin = 0;
    end else if (cfg_load) begin
      m_active = 1; m_tail = 0; m_head = 0; m_phase = 1; m_last = int'(cfg_qsize);
      m_base = cfg_base; m_ien = cfg_irq_en; m_ven = cfg_vec_en; m_vec = cfg_vector;
      m_posted = 0; m_msg = 0; m_pin = 0;
    end else begin
      fire = m_posted && !acc;
      m_msg = fire && m_ien && m_ven;
      m_pin = fire && m_ien && !m_ven;
      m_posted = acc;
      if (acc) begin
        m_tail = nt;
        if (nt == 0) m_phase = !m_phase;
        void'(pend.pop_front());
      end
      if (head_we && int'(head_val) <= m_last) m_head = int'(head_val);
    end
    cfg_load = 1'b0;
    head_we  = 1'b0;
    @(negedge clk);
  endtask

  task automatic cycle();
    drive(); #2; compare(); advance();
  endtask

  task automatic load(input logic [15:0] qs, input bit ien, input bit ven, input logic [7:0] v);
    cfg_base = 32'h1000; cfg_qsize = qs; cfg_irq_en = ien; cfg_vec_en = ven; cfg_vector = v;
    cfg_load = 1'b1;
    cycle();
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      rdy_mode = 1;
      feed_en = ($urandom_range(0, 3) != 0);
      if (pend.size() < 4 && $urandom_range(0, 1) == 1) push();
      if ($urandom_range(0, 3) == 0) begin
        head_we = 1'b1;
        head_val = ($urandom_range(0, 5) == 0) ? 16'($urandom_range(0, m_last + 3)) : 16'(m_tail);
      end
      cycle();
    end
    feed_en = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_load = 0; cfg_base = 0; cfg_qsize = 0; cfg_irq_en = 0; cfg_vec_en = 0;
    cfg_vector = 0; cpl_valid = 0; cpl_cid = 0; cpl_sqid = 0; cpl_sq_head = 0; cpl_status = 0;
    head_we = 0; head_val = 0; wr_ready = 0;
    @(negedge clk);
    repeat (3) advance();
    rst_n = 1'b1;
    push(); push();
    // R1: nothing posts before the ring is loaded
    drive(); #2; chk(!wr_valid && !cpl_ready, "R1", 128'({wr_valid, cpl_ready}), 128'(0)); compare(); advance();
    cycle();
    load(16'd3, 1, 1, 8'd5);
    push();
    // R1: first entry at base, phase 1
    drive(); #2; chk(wr_addr === 32'h1000 && wr_data[112] === 1'b1, "R1", 128'(wr_addr), 128'(32'h1000));
    compare(); advance();
    cycle(); cycle();
    cycle();
    // R9: vectored pulse after the batch
    drive(); #2; chk(irq_msg_valid === 1'b1 && irq_msg_vector === 8'd5, "R9",
                     128'({irq_msg_valid, irq_msg_vector}), 128'({1'b1, 8'd5}));
    compare(); advance();
    push();
    // R6: tail 3, head 0 -> full
    drive(); #2; chk(wr_valid === 1'b0, "R6", 128'(wr_valid), 128'(0)); compare(); advance();
    head_we = 1; head_val = 16'd7; cycle();
    // R7: out-of-range head ignored, still full
    drive(); #2; chk(wr_valid === 1'b0, "R7", 128'(wr_valid), 128'(0)); compare(); advance();
    head_we = 1; head_val = 16'd2; cycle();
    // R3: posts at slot 3
    drive(); #2; chk(wr_addr === 32'h1030, "R3", 128'(wr_addr), 128'(32'h1030)); compare(); advance();
    push();
    // R5: wrapped to slot 0 with inverted phase
    drive(); #2; chk(wr_addr === 32'h1000 && wr_data[112] === 1'b0, "R5",
                     128'({wr_addr, wr_data[112]}), 128'({32'h1000, 1'b0}));
    compare(); advance();
    head_we = 1; head_val = 16'd1; cycle();
    push(); rdy_mode = 2;
    for (int i = 0; i < 3; i++) begin
      // R4: stalled write holds address
      drive(); #2; chk(wr_valid === 1'b1 && wr_addr === 32'h1010, "R4",
                       128'({wr_valid, wr_addr}), 128'({1'b1, 32'h1010}));
      compare(); advance();
    end
    rdy_mode = 0; cycle(); cycle();
    random_run(300);
    // R11: depth 2 holds one entry, pin interrupt mode
    load(16'd1, 1, 0, 8'd9);
    rdy_mode = 0;
    while (pend.size() < 3) push();
    cycle();
    drive(); #2; chk(wr_valid === 1'b0, "R11", 128'(wr_valid), 128'(0)); compare(); advance();
    // R10: pin pulse instead of message
    drive(); #2; chk(irq_pin_pulse === 1'b1 && irq_msg_valid === 1'b0, "R10",
                     128'({irq_pin_pulse, irq_msg_valid}), 128'(2'b10));
    compare(); advance();
    random_run(200);
    load(16'd7, 0, 1, 8'd3);
    random_run(300);
    load(16'd7, 1, 1, 8'd12);
    random_run(300);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule